// File: doc/BRIEF.md
# Low-Power Mode Entry and Exit Sequencer

This block decides what happens when the core executes a wait-for-interrupt (WFI) or wait-for-event (WFE) instruction. Two control bits pick one of three power-saving states. With the depth bit clear, only the CPU clock stops (light sleep). With the depth bit set and the standby-select bit clear, every core-domain clock stops and the oscillators and PLLs turn off (deep sleep), and the regulator may drop into its low-power mode. With both bits set, core-domain power is removed and the regulator is switched off (standby). In light and deep sleep the block drives the clock-gate, oscillator, regulator and power-switch controls and brings them back once a wakeup qualifies. Leaving standby always requests a power-on reset.

Wakeups depend on the instruction that put the core to sleep. A WFI sleep ends on any interrupt line and a WFE sleep ends on any event line. A deep-sleep request is refused while an external-line pending flag or an RTC alarm, timestamp or tamper flag is set, and the core simply keeps running. After deep sleep the system clock is forced back to the internal RC oscillator. If the regulator was in low-power mode, the core waits a programmable extra number of cycles first. Standby ends on the reset pin, an RTC event, a watchdog reset, or a rising edge on an asynchronous wakeup pin. That pin passes through a two-flop synchronizer and an edge detector.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the CPU clock, domain clock, oscillator enable and domain power are all 1. The regulator-off, regulator-low-power, power-on-reset request, wake acknowledge, clock-select, skip and standby flag outputs are all 0.
- R2: A WFI or WFE strobe in run with `sleep_deep_i`=0 drops `cpu_clk_en_o` to 0 from the next cycle. The domain clock, oscillator enable and domain power stay 1, and the regulator outputs stay 0.
- R3: A strobe in run with `sleep_deep_i`=1 and `stby_sel_i`=0, and no pending flag, enters deep sleep on the next cycle. Both clocks and `osc_en_o` go to 0 and domain power stays 1. `reg_lp_o` equals the `reg_lp_sel_i` value seen at entry, and later changes of that input have no effect.
- R4: A deep-sleep request made while `ext_pend_any_i` or `rtc_flag_any_i` is 1 is refused. The outputs stay as in run, and `entry_skip_o` is 1 for exactly the one cycle after the strobe.
- R5: A sleep entered by WFI (light or deep) ends only when some `ext_irq_i` bit is 1. A sleep entered by WFE ends only when some `ext_evt_i` bit is 1. The other set of lines has no effect.
- R6: A qualified wakeup in deep sleep with the regulator in normal mode gives one cycle with `osc_en_o`=1 and both clocks still 0. The block then returns to run, with `wake_ack_o` and `sysclk_rc_sel_o` each 1 for exactly that first run cycle.
- R7: When deep sleep was entered with the regulator in low-power mode, the clocks come back `WAKE_DLY` cycles later than in R6.
- R8: A qualified wakeup in light sleep restores `cpu_clk_en_o` on the next cycle, with `wake_ack_o` 1 for that one cycle and `sysclk_rc_sel_o` 0.
- R9: A strobe in run with both `sleep_deep_i` and `stby_sel_i` at 1 enters standby even when pending flags are set. In standby all clocks and `osc_en_o` are 0, `reg_off_o`=1 and `dom_pwr_on_o`=0. `stby_flag_o` becomes 1 and stays 1 until `rst_n`.
- R10: In standby, a 1 on `rst_pin_wake_i`, `rtc_evt_i` or `wdg_rst_i` makes `por_req_o` 1 for exactly one cycle, with power and oscillators back on. The next cycle is run with `wake_ack_o`=0. Interrupt and event lines have no effect in standby.
- R11: A 0-to-1 change on `wkup_pin_i` applied just after a clock edge raises `por_req_o` from standby in the cycle after the third rising edge. A pin that is already high at standby entry does not wake the block.
- R12: Strobes are ignored in every state except run. If WFI and WFE are strobed together, the entry counts as WFI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| sleep_deep_i | input | 1 | Sleep-depth control bit (0 light, 1 deep/standby) |
| stby_sel_i | input | 1 | Standby select when depth bit is 1 |
| reg_lp_sel_i | input | 1 | Regulator low-power request for deep sleep |
| wfi_i | input | 1 | One-cycle strobe: core executed WFI |
| wfe_i | input | 1 | One-cycle strobe: core executed WFE |
| ext_irq_i | input | N_LINES | External interrupt lines |
| ext_evt_i | input | N_LINES | External event lines |
| ext_pend_any_i | input | 1 | OR of external-line pending flags |
| rtc_flag_any_i | input | 1 | OR of RTC alarm/timestamp/tamper flags |
| rst_pin_wake_i | input | 1 | External reset pin request |
| rtc_evt_i | input | 1 | RTC alarm/timestamp/tamper event |
| wdg_rst_i | input | 1 | Watchdog reset request |
| wkup_pin_i | input | 1 | Asynchronous standby wakeup pin |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| dom_clk_en_o | output | 1 | Core-domain clock gate enable |
| osc_en_o | output | 1 | Oscillator and PLL enable |
| reg_lp_o | output | 1 | Regulator low-power mode |
| reg_off_o | output | 1 | Regulator shut-off |
| dom_pwr_on_o | output | 1 | Core-domain power switch |
| sysclk_rc_sel_o | output | 1 | One-cycle pulse forcing the system clock to the RC oscillator |
| wake_ack_o | output | 1 | One-cycle pulse on return to run from sleep |
| entry_skip_o | output | 1 | One-cycle pulse on a refused deep-sleep request |
| stby_flag_o | output | 1 | Sticky: standby was entered |
| por_req_o | output | 1 | Power-on reset request on standby exit |

## Verification
The bench builds the block with `WAKE_DLY`=5 and `N_LINES`=4. The short delay lets the bench count the whole low-power wakeup window cycle by cycle and compare it against the one-cycle normal-regulator window. Four lines per side are enough to wake from a non-zero bit position and to show that the wrong kind of line is ignored. A behavioural model tracks mode, latched wait kind, remaining delay and the synchronizer history, and its outputs are compared with the block's outputs on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    S_RUN   = 3'd0,
    S_SLEEP = 3'd1,
    S_DEEP  = 3'd2,
    S_DWAKE = 3'd3,
    S_STBY  = 3'd4,
    S_POR   = 3'd5
  } lpm_state_e;

  typedef struct packed {
    logic cpu_clk_en;
    logic dom_clk_en;
    logic osc_en;
    logic reg_lp;
    logic reg_off;
    logic dom_pwr_on;
    logic por_req;
  } lpm_drive_t;

endpackage

// File: rtl/lpm_wkup_edge.sv
module lpm_wkup_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic [SYNC_STAGES:0] chain_q;
  logic [SYNC_STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R11: one pin transition gives a single-cycle pulse
  p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o)
    else $error("wakeup pin pulse longer than one cycle");

endmodule

// File: rtl/lpm_wake_cnt.sv
module lpm_wake_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R7: the delay window shrinks by exactly one per decrement cycle
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("wakeup delay counter skipped");

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               wait_evt_i,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] evt_i,
  input  logic               rst_pin_i,
  input  logic               rtc_evt_i,
  input  logic               wdg_rst_i,
  input  logic               pin_rise_i,
  output logic               sleep_wake_o,
  output logic               stby_wake_o
);

  logic any_irq;
  logic any_evt;

  always_comb begin
    any_irq      = |irq_i;
    any_evt      = |evt_i;
    sleep_wake_o = wait_evt_i ? any_evt : any_irq;
    stby_wake_o  = rst_pin_i | rtc_evt_i | wdg_rst_i | pin_rise_i;
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned WAKE_DLY = 16,
  parameter int unsigned CNT_W    = $clog2(WAKE_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_deep_i,
  input  logic             cfg_stby_i,
  input  logic             cfg_reg_lp_i,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             pend_block_i,
  input  logic             sleep_wake_i,
  input  logic             stby_wake_i,
  input  logic             cnt_zero_i,
  output logic             wait_evt_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output lpm_drive_t       drive_o,
  output logic             wake_ack_o,
  output logic             rc_sel_o,
  output logic             skip_o,
  output logic             stby_flag_o
);

  lpm_state_e state_q, state_d;
  logic       wait_evt_q, wait_evt_d;
  logic       lp_q, lp_d;
  logic       ack_q, ack_d;
  logic       rc_q, rc_d;
  logic       skip_q, skip_d;
  logic       stby_q, stby_d;
  logic       entry;
  logic       capture_en;
  logic       state_en;
  logic       lp_en;

  assign entry      = wfi_i | wfe_i;
  assign capture_en = (state_q == S_RUN) & entry;

  // next-state process
  always_comb begin
    state_d    = state_q;
    wait_evt_d = ~wfi_i;
    lp_d       = lp_q;
    ack_d      = 1'b0;
    rc_d       = 1'b0;
    skip_d     = 1'b0;
    stby_d     = stby_q;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    unique case (state_q)
      S_RUN: begin
        if (entry) begin
          if (!cfg_deep_i) begin
            state_d = S_SLEEP;
          end else if (cfg_stby_i) begin
            state_d = S_STBY;
            stby_d  = 1'b1;
          end else if (pend_block_i) begin
            skip_d  = 1'b1;
          end else begin
            state_d = S_DEEP;
            lp_d    = cfg_reg_lp_i;
          end
        end
      end
      S_SLEEP: begin
        if (sleep_wake_i) begin
          state_d = S_RUN;
          ack_d   = 1'b1;
        end
      end
      S_DEEP: begin
        if (sleep_wake_i) begin
          state_d    = S_DWAKE;
          cnt_load_o = 1'b1;
        end
      end
      S_DWAKE: begin
        if (cnt_zero_i) begin
          state_d = S_RUN;
          ack_d   = 1'b1;
          rc_d    = 1'b1;
          lp_d    = 1'b0;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      S_STBY: begin
        if (stby_wake_i) state_d = S_POR;
      end
      S_POR: begin
        state_d = S_RUN;
      end
      default: begin
        state_d = S_RUN;
      end
    endcase
  end

  assign state_en  = (state_d != state_q);
  assign lp_en     = capture_en | (state_q == S_DWAKE);
  assign cnt_val_o = lp_q ? CNT_W'(WAKE_DLY) : '0;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_RUN;
      wait_evt_q <= 1'b0;
      lp_q       <= 1'b0;
      ack_q      <= 1'b0;
      rc_q       <= 1'b0;
      skip_q     <= 1'b0;
      stby_q     <= 1'b0;
    end else begin
      if (state_en)   state_q    <= state_d;
      if (capture_en) wait_evt_q <= wait_evt_d;
      if (lp_en)      lp_q       <= lp_d;
      ack_q  <= ack_d;
      rc_q   <= rc_d;
      skip_q <= skip_d;
      stby_q <= stby_d;
    end
  end

  // output decode from state
  always_comb begin
    drive_o = '{cpu_clk_en: 1'b1, dom_clk_en: 1'b1, osc_en: 1'b1, reg_lp: 1'b0,
                reg_off: 1'b0, dom_pwr_on: 1'b1, por_req: 1'b0};
    unique case (state_q)
      S_SLEEP: drive_o.cpu_clk_en = 1'b0;
      S_DEEP: begin
        drive_o.cpu_clk_en = 1'b0;
        drive_o.dom_clk_en = 1'b0;
        drive_o.osc_en     = 1'b0;
        drive_o.reg_lp     = lp_q;
      end
      S_DWAKE: begin
        drive_o.cpu_clk_en = 1'b0;
        drive_o.dom_clk_en = 1'b0;
      end
      S_STBY: begin
        drive_o.cpu_clk_en = 1'b0;
        drive_o.dom_clk_en = 1'b0;
        drive_o.osc_en     = 1'b0;
        drive_o.reg_off    = 1'b1;
        drive_o.dom_pwr_on = 1'b0;
      end
      S_POR: begin
        drive_o.cpu_clk_en = 1'b0;
        drive_o.dom_clk_en = 1'b0;
        drive_o.por_req    = 1'b1;
      end
      default: ;
    endcase
  end

  assign wait_evt_o  = wait_evt_q;
  assign wake_ack_o  = ack_q;
  assign rc_sel_o    = rc_q;
  assign skip_o      = skip_q;
  assign stby_flag_o = stby_q;

  // R4: a refused entry leaves the sequencer in run
  p_skip_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> (state_q == S_RUN))
    else $error("skip pulse outside run");

  // R6: deep sleep only leaves through the wake window
  p_deep_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DEEP) |=> (state_q inside {S_DEEP, S_DWAKE}))
    else $error("deep sleep left without wake window");

  // R6: clock-select pulse only follows the wake window
  p_rc_after_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q |-> ($past(state_q) == S_DWAKE))
    else $error("clock select pulse without deep wake");

  // R8: light sleep returns only to run
  p_light_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SLEEP) |=> (state_q inside {S_SLEEP, S_RUN}))
    else $error("light sleep left to a wrong state");

  // R9: standby flag is sticky
  p_stby_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stby_q |=> stby_q)
    else $error("standby flag cleared");

  // R10: standby exits only through the reset request
  p_stby_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STBY) |=> (state_q inside {S_STBY, S_POR}))
    else $error("standby left without reset request");

  // R10: reset request lasts one cycle
  p_por_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POR) |=> (state_q == S_RUN))
    else $error("reset request longer than one cycle");

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_LINES     = 8,
  parameter int unsigned WAKE_DLY    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_deep_i,
  input  logic               stby_sel_i,
  input  logic               reg_lp_sel_i,
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic [N_LINES-1:0] ext_irq_i,
  input  logic [N_LINES-1:0] ext_evt_i,
  input  logic               ext_pend_any_i,
  input  logic               rtc_flag_any_i,
  input  logic               rst_pin_wake_i,
  input  logic               rtc_evt_i,
  input  logic               wdg_rst_i,
  input  logic               wkup_pin_i,
  output logic               cpu_clk_en_o,
  output logic               dom_clk_en_o,
  output logic               osc_en_o,
  output logic               reg_lp_o,
  output logic               reg_off_o,
  output logic               dom_pwr_on_o,
  output logic               sysclk_rc_sel_o,
  output logic               wake_ack_o,
  output logic               entry_skip_o,
  output logic               stby_flag_o,
  output logic               por_req_o
);

  localparam int unsigned CNT_W = $clog2(WAKE_DLY + 1);

  logic             pin_rise;
  logic             wait_evt;
  logic             sleep_wake;
  logic             stby_wake;
  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  lpm_drive_t       drive;

  lpm_wkup_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (wkup_pin_i),
    .rise_o (pin_rise)
  );

  lpm_wake_qual #(.N_LINES(N_LINES)) u_qual (
    .wait_evt_i   (wait_evt),
    .irq_i        (ext_irq_i),
    .evt_i        (ext_evt_i),
    .rst_pin_i    (rst_pin_wake_i),
    .rtc_evt_i    (rtc_evt_i),
    .wdg_rst_i    (wdg_rst_i),
    .pin_rise_i   (pin_rise),
    .sleep_wake_o (sleep_wake),
    .stby_wake_o  (stby_wake)
  );

  lpm_wake_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  lpm_seq #(.WAKE_DLY(WAKE_DLY), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_deep_i   (sleep_deep_i),
    .cfg_stby_i   (stby_sel_i),
    .cfg_reg_lp_i (reg_lp_sel_i),
    .wfi_i        (wfi_i),
    .wfe_i        (wfe_i),
    .pend_block_i (ext_pend_any_i | rtc_flag_any_i),
    .sleep_wake_i (sleep_wake),
    .stby_wake_i  (stby_wake),
    .cnt_zero_i   (cnt_zero),
    .wait_evt_o   (wait_evt),
    .cnt_load_o   (cnt_load),
    .cnt_val_o    (cnt_val),
    .cnt_dec_o    (cnt_dec),
    .drive_o      (drive),
    .wake_ack_o   (wake_ack_o),
    .rc_sel_o     (sysclk_rc_sel_o),
    .skip_o       (entry_skip_o),
    .stby_flag_o  (stby_flag_o)
  );

  assign cpu_clk_en_o = drive.cpu_clk_en;
  assign dom_clk_en_o = drive.dom_clk_en;
  assign osc_en_o     = drive.osc_en;
  assign reg_lp_o     = drive.reg_lp;
  assign reg_off_o    = drive.reg_off;
  assign dom_pwr_on_o = drive.dom_pwr_on;
  assign por_req_o    = drive.por_req;

  // R2: the CPU clock never runs while the domain clock is stopped
  p_clk_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en_o |-> dom_clk_en_o)
    else $error("cpu clock on with domain clock off");

  // R9: domain unpowered only with regulator off
  p_pwr_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_pwr_on_o |-> (reg_off_o && !osc_en_o))
    else $error("domain off with regulator or oscillator on");

  // R6: wake acknowledge is a single-cycle pulse
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack_o |=> !wake_ack_o)
    else $error("wake acknowledge held");

endmodule

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;

  localparam int NL  = 4;
  localparam int DLY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_deep = 1'b0, stby_sel = 1'b0, reg_lp_sel = 1'b0;
  logic wfi = 1'b0, wfe = 1'b0;
  logic [NL-1:0] irq = '0, evt = '0;
  logic pend = 1'b0, rtcf = 1'b0, rstpin = 1'b0, rtce = 1'b0, wdg = 1'b0, wpin = 1'b0;
  logic cpu_en, dom_en, osc_en, reg_lp, reg_off, pwr_on, rc_sel, ack, skip, sflag, por;

  lpm_ctrl #(.N_LINES(NL), .WAKE_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_deep_i(sleep_deep), .stby_sel_i(stby_sel),
    .reg_lp_sel_i(reg_lp_sel), .wfi_i(wfi), .wfe_i(wfe), .ext_irq_i(irq), .ext_evt_i(evt),
    .ext_pend_any_i(pend), .rtc_flag_any_i(rtcf), .rst_pin_wake_i(rstpin), .rtc_evt_i(rtce),
    .wdg_rst_i(wdg), .wkup_pin_i(wpin), .cpu_clk_en_o(cpu_en), .dom_clk_en_o(dom_en),
    .osc_en_o(osc_en), .reg_lp_o(reg_lp), .reg_off_o(reg_off), .dom_pwr_on_o(pwr_on),
    .sysclk_rc_sel_o(rc_sel), .wake_ack_o(ack), .entry_skip_o(skip), .stby_flag_o(sflag),
    .por_req_o(por)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 run 1 light 2 deep 3 waking 4 standby 5 reset-request
  int m_mode;
  bit m_evt, m_lp, m_ack, m_rc, m_skip, m_sflag;
  int m_wait;
  bit pinq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_evt = 0; m_lp = 0; m_ack = 0; m_rc = 0; m_skip = 0; m_sflag = 0;
      m_wait = 0; pinq = '{0, 0, 0};
    end else begin
      bit rise;
      bit woke;
      rise = pinq[1] && !pinq[2];
      woke = m_evt ? (evt != 0) : (irq != 0);
      m_ack = 0; m_rc = 0; m_skip = 0;
      case (m_mode)
        0: if (wfi || wfe) begin
             m_evt = !wfi;
             if (!sleep_deep) m_mode = 1;
             else if (stby_sel) begin m_mode = 4; m_sflag = 1; end
             else if (pend || rtcf) m_skip = 1;
             else begin m_mode = 2; m_lp = reg_lp_sel; end
           end
        1: if (woke) begin m_mode = 0; m_ack = 1; end
        2: if (woke) begin m_mode = 3; m_wait = m_lp ? DLY : 0; end
        3: if (m_wait == 0) begin m_mode = 0; m_ack = 1; m_rc = 1; m_lp = 0; end
           else m_wait--;
        4: if (rstpin || rtce || wdg || rise) m_mode = 5;
        default: m_mode = 0;
      endcase
      pinq.push_front(wpin);
      void'(pinq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model cpu_clk_en", 32'(cpu_en), 32'(m_mode == 0));
      chk("R3 model dom_clk_en", 32'(dom_en), 32'(m_mode <= 1));
      chk("R3 model osc_en", 32'(osc_en), 32'(m_mode <= 1 || m_mode == 3 || m_mode == 5));
      chk("R7 model reg_lp", 32'(reg_lp), 32'(m_mode == 2 && m_lp));
      chk("R9 model reg_off", 32'(reg_off), 32'(m_mode == 4));
      chk("R9 model dom_pwr_on", 32'(pwr_on), 32'(m_mode != 4));
      chk("R10 model por_req", 32'(por), 32'(m_mode == 5));
      chk("R8 model wake_ack", 32'(ack), 32'(m_ack));
      chk("R6 model rc_sel", 32'(rc_sel), 32'(m_rc));
      chk("R4 model skip", 32'(skip), 32'(m_skip));
      chk("R9 model stby_flag", 32'(sflag), 32'(m_sflag));
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic pulse_wfi(); wfi = 1'b1; step(); wfi = 1'b0; endtask
  task automatic pulse_wfe(); wfe = 1'b1; step(); wfe = 1'b0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 cpu", 32'(cpu_en), 1); chk("R1 dom", 32'(dom_en), 1);
    chk("R1 osc", 32'(osc_en), 1); chk("R1 pwr", 32'(pwr_on), 1);
    chk("R1 reg_off", 32'(reg_off), 0); chk("R1 flag", 32'(sflag), 0);
    chk("R1 por", 32'(por), 0);

    // light sleep by WFI
    sleep_deep = 0; pulse_wfi();
    chk("R2 cpu off", 32'(cpu_en), 0); chk("R2 dom on", 32'(dom_en), 1);
    chk("R2 osc on", 32'(osc_en), 1);
    evt = 4'b0010; step(); evt = '0;
    chk("R5 event ignored after WFI", 32'(cpu_en), 0);
    irq = 4'b0100; step(); irq = '0;
    chk("R8 cpu back", 32'(cpu_en), 1); chk("R8 ack", 32'(ack), 1);
    chk("R8 no rc_sel", 32'(rc_sel), 0);
    step(); chk("R8 ack one cycle", 32'(ack), 0);

    // light sleep by WFE
    pulse_wfe();
    irq = 4'b0001; step(); irq = '0;
    chk("R5 irq ignored after WFE", 32'(cpu_en), 0);
    evt = 4'b1000; step(); evt = '0;
    chk("R5 event wakes WFE sleep", 32'(cpu_en), 1);

    // deep sleep, normal regulator
    sleep_deep = 1; stby_sel = 0; reg_lp_sel = 0; pulse_wfi();
    chk("R3 cpu off", 32'(cpu_en), 0); chk("R3 dom off", 32'(dom_en), 0);
    chk("R3 osc off", 32'(osc_en), 0); chk("R3 reg_lp", 32'(reg_lp), 0);
    chk("R3 pwr on", 32'(pwr_on), 1);
    irq = 4'b0010; step(); irq = '0;
    chk("R6 osc up", 32'(osc_en), 1); chk("R6 clk still off", 32'(dom_en), 0);
    step();
    chk("R6 run", 32'(cpu_en), 1); chk("R6 rc_sel", 32'(rc_sel), 1);
    chk("R6 ack", 32'(ack), 1);
    step(); chk("R6 rc_sel one cycle", 32'(rc_sel), 0);

    // deep sleep, low-power regulator, WFE
    reg_lp_sel = 1; pulse_wfe();
    chk("R3 reg_lp latched", 32'(reg_lp), 1);
    reg_lp_sel = 0; step();
    chk("R3 reg_lp held", 32'(reg_lp), 1);
    irq = 4'b1111; step(); irq = '0;
    chk("R5 irq ignored in WFE deep", 32'(osc_en), 0);
    sleep_deep = 0; pulse_wfi();
    chk("R12 strobe ignored in deep", 32'(osc_en), 0);
    chk("R12 still deep", 32'(dom_en), 0);
    sleep_deep = 1;
    evt = 4'b0100; step(); evt = '0;
    n = 0;
    while (!cpu_en && n < 100) begin step(); n++; end
    chk("R7 wake window", 32'(n), 32'(DLY + 1));
    chk("R7 rc_sel", 32'(rc_sel), 1);
    step();

    // refused entries
    pend = 1; pulse_wfi();
    chk("R4 skip pulse", 32'(skip), 1); chk("R4 stays run", 32'(cpu_en), 1);
    step(); chk("R4 skip one cycle", 32'(skip), 0);
    pend = 0; rtcf = 1; pulse_wfe();
    chk("R4 rtc flag skip", 32'(skip), 1); chk("R4 osc on", 32'(osc_en), 1);
    rtcf = 0; step();

    // standby
    stby_sel = 1; pend = 1; pulse_wfi(); pend = 0;
    chk("R9 pwr off", 32'(pwr_on), 0); chk("R9 reg_off", 32'(reg_off), 1);
    chk("R9 osc off", 32'(osc_en), 0); chk("R9 flag", 32'(sflag), 1);
    irq = '1; evt = '1; step(); irq = '0; evt = '0;
    chk("R10 lines ignored", 32'(por), 0); chk("R10 still off", 32'(pwr_on), 0);
    rtce = 1; step(); rtce = 0;
    chk("R10 rtc por", 32'(por), 1); chk("R10 pwr back", 32'(pwr_on), 1);
    step();
    chk("R10 por one cycle", 32'(por), 0); chk("R10 run", 32'(cpu_en), 1);
    chk("R10 no ack", 32'(ack), 0); chk("R9 flag sticky", 32'(sflag), 1);
    pulse_wfe(); wdg = 1; step(); wdg = 0;
    chk("R10 watchdog por", 32'(por), 1); step();
    pulse_wfi(); rstpin = 1; step(); rstpin = 0;
    chk("R10 reset pin por", 32'(por), 1); step();

    // wakeup pin through synchronizer
    pulse_wfi();
    wpin = 1; step();
    chk("R11 edge 1", 32'(por), 0); step();
    chk("R11 edge 2", 32'(por), 0); step();
    chk("R11 edge 3", 32'(por), 1); step();
    pulse_wfi();
    repeat (8) step();
    chk("R11 held high no wake", 32'(por), 0); chk("R11 still standby", 32'(pwr_on), 0);
    wpin = 0; repeat (3) step();
    wpin = 1; repeat (3) step();
    chk("R11 second edge", 32'(por), 1); step();

    // simultaneous strobes count as WFI; strobes ignored in light sleep
    sleep_deep = 0; stby_sel = 0;
    wfi = 1; wfe = 1; step(); wfi = 0; wfe = 0;
    chk("R12 both strobes sleep", 32'(cpu_en), 0);
    sleep_deep = 1; stby_sel = 1; pulse_wfe();
    chk("R12 ignored in light dom", 32'(dom_en), 1);
    chk("R12 ignored in light pwr", 32'(pwr_on), 1);
    sleep_deep = 0; stby_sel = 0;
    evt = 4'b0001; step(); evt = '0;
    chk("R12 event ignored", 32'(cpu_en), 0);
    irq = 4'b1000; step(); irq = '0;
    chk("R12 irq wakes", 32'(cpu_en), 1);
    repeat (2) step();
    finish_run();
  end

endmodule